// File: doc/BRIEF.md
# Branch Target Trace Output Encoder

This block produces a real-time program trace for a pipelined processor core on two 4-bit ports: a status port and a data port. In ordinary cycles the status port repeats the per-instruction status code the core presents. When the core reports a taken change of flow whose target was computed indirectly, it raises a capture strobe with the 32-bit target. Such branches are returns from exceptions or subroutines, register-indirect or indexed jumps and calls, and exception vectors. The block then emits the taken-branch code on the status port. In the next cycle it emits a length marker. The configured low-order bytes of the target are then streamed out on the data port, one nibble per cycle.

A small nibble FIFO sits between the capture and the data port. Because of it, the status port moves on to later instructions while earlier addresses are still draining. A capture is accepted only when the FIFO can take the whole address in one cycle. Otherwise the block holds the capture, asserts a stall to the pipeline and shows status 0x0 until room appears. The stall is also raised for the single marker slot, because the status port is busy in that cycle.

Top module: `trace_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `traceStatus`, `traceData` and `pipeStall` are all 0, and the FIFO is empty.
- R2: Inputs are sampled at a rising edge where `pipeStall` is low. When `capValid` is low, `traceStatus` shows the sampled `instStatus` after that edge.
- R3: An accepted capture with `cfgBytes` nonzero shows 0x5 on `traceStatus` for one cycle with `pipeStall` high. The next cycle shows the marker `{2'b10, cfgBytes}` (0x9, 0xA, 0xB for 2, 3, 4 bytes) with `pipeStall` low.
- R4: `cfgBytes` = 1, 2, 3 selects 2, 3, 4 target bytes. The accepted capture pushes 2×bytes nibbles, least significant nibble of the target first, and they appear on `traceData` in that order.
- R5: The data port drains at one nibble per cycle, independently of the status port. New instructions are traced on `traceStatus` while earlier nibbles are still being shown.
- R6: A capture is accepted only when the FIFO free space at the sampling edge (depth minus occupancy before that edge's pop) is at least 2×bytes. Otherwise `traceStatus` shows 0x0 and `pipeStall` stays high. The held capture is retried on every edge and, once it fits, is emitted as in R3.
- R7: On any edge where `pipeStall` is high, `instStatus`, `capValid`, `capTarget` and `cfgBytes` are ignored.
- R8: When the FIFO is empty at an edge, `traceData` shows 0x0 after that edge.
- R9: With `cfgBytes` = 0 the capture feature is off. A capture shows 0x5 for one cycle, with no marker, no data pushed and no stall.
- R10: FIFO occupancy never exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instStatus | input | 4 | Per-instruction status code from the core |
| capValid | input | 1 | Taken indirect change of flow with target to capture |
| capTarget | input | ADDR_W | Branch target address |
| cfgBytes | input | 2 | 0 off, 1/2/3 = 2/3/4 target bytes |
| traceStatus | output | 4 | Registered trace status code |
| traceData | output | 4 | Registered trace data nibble |
| pipeStall | output | 1 | Registered back-pressure to the pipeline |

## Verification
Each result is due at a fixed cycle after the edge that samples the inputs. An ordinary status code, the 0x5 code and the stall flag appear one cycle later, and the marker appears two cycles later. The first nibble of a capture also appears two cycles later when the FIFO was empty, and each later nibble one cycle after the previous one queued ahead of it. The bench keeps a behavioural model with a nibble queue that advances once per rising edge, using the same inputs the design sees. It compares all three outputs against this model at every falling edge. During stalls the bench deliberately drives conflicting inputs, so that ignoring them is checked at the ports.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MARK = 2'd1,
    ST_WAIT = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadHold;
    logic pushLive;
    logic pushHeld;
  } dpStrobe_t;

  localparam logic [3:0] CODE_TAKEN = 4'h5;
  localparam logic [3:0] CODE_HOLD  = 4'h0;

  function automatic logic [3:0] nibsFor(input logic [1:0] cfg);
    return {1'b0, cfg, 1'b0} + 4'd2;
  endfunction

endpackage

// File: rtl/trace_datapath.sv
module trace_datapath
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] liveTarget,
  input  logic [1:0]        liveCfg,
  output logic [CNT_W-1:0]  freeSlots,
  output logic [1:0]        heldCfg,
  output logic [3:0]        dataOut
);

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int MAX_NIBS = 8;

  logic [ADDR_W-1:0] heldTarget;
  logic [ADDR_W-1:0] pushTarget;
  logic [1:0]        pushCfg;
  logic [CNT_W-1:0]  pushCnt;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic              popNow;
  logic [3:0]        mem [DEPTH];
  logic [3:0]        laneNib [MAX_NIBS];

  always_comb begin
    pushTarget = strobe.pushHeld ? heldTarget : liveTarget;
    pushCfg    = strobe.pushHeld ? heldCfg    : liveCfg;
    pushCnt    = (strobe.pushLive || strobe.pushHeld) ? CNT_W'(nibsFor(pushCfg)) : '0;
    popNow     = (count != '0);
    freeSlots  = CNT_W'(DEPTH) - count;
  end

  for (genvar g = 0; g < MAX_NIBS; g++) begin : g_lane
    assign laneNib[g] = pushTarget[4*g +: 4];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_NIBS; i++) begin
      if (i < int'(pushCnt)) mem[wrPtr + PTR_W'(i)] <= laneNib[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldTarget <= '0;
      heldCfg    <= '0;
      rdPtr      <= '0;
      wrPtr      <= '0;
      count      <= '0;
      dataOut    <= '0;
    end else begin
      if (strobe.loadHold) begin
        heldTarget <= liveTarget;
        heldCfg    <= liveCfg;
      end
      if (popNow) begin
        dataOut <= mem[rdPtr];
        rdPtr   <= rdPtr + PTR_W'(1);
      end else begin
        dataOut <= '0;
      end
      wrPtr <= wrPtr + PTR_W'(pushCnt);
      count <= count + pushCnt - CNT_W'(popNow);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_push_fits_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushCnt != '0) |-> (pushCnt <= freeSlots));

  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |=> (dataOut == 4'h0));

  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.pushLive && strobe.pushHeld));

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       instStatus,
  input  logic             capValid,
  input  logic [1:0]       cfgBytes,
  input  logic [CNT_W-1:0] freeSlots,
  input  logic [1:0]       heldCfg,
  output dpStrobe_t        strobe,
  output logic [3:0]       statusOut,
  output logic             stall
);

  ctrlState_t state, nextState;
  logic [3:0] nextStatus;
  logic       liveFits, heldFits;

  always_comb begin
    liveFits   = CNT_W'(nibsFor(cfgBytes)) <= freeSlots;
    heldFits   = CNT_W'(nibsFor(heldCfg)) <= freeSlots;
    strobe     = '0;
    nextState  = state;
    nextStatus = CODE_HOLD;
    case (state)
      ST_IDLE: begin
        if (capValid && cfgBytes != 2'd0) begin
          strobe.loadHold = 1'b1;
          if (liveFits) begin
            strobe.pushLive = 1'b1;
            nextStatus      = CODE_TAKEN;
            nextState       = ST_MARK;
          end else begin
            nextStatus = CODE_HOLD;
            nextState  = ST_WAIT;
          end
        end else if (capValid) begin
          nextStatus = CODE_TAKEN;
        end else begin
          nextStatus = instStatus;
        end
      end
      ST_MARK: begin
        nextStatus = {2'b10, heldCfg};
        nextState  = ST_IDLE;
      end
      ST_WAIT: begin
        if (heldFits) begin
          strobe.pushHeld = 1'b1;
          nextStatus      = CODE_TAKEN;
          nextState       = ST_MARK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      statusOut <= CODE_HOLD;
      stall     <= 1'b0;
    end else begin
      state     <= nextState;
      statusOut <= nextStatus;
      stall     <= (nextState != ST_IDLE);
    end
  end

  assert_taken_then_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && capValid && cfgBytes != 2'd0 && liveFits) |=> (stall && statusOut == CODE_TAKEN));

  assert_marker_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stall && statusOut == CODE_TAKEN) |=> (!stall && statusOut >= 4'h9 && statusOut <= 4'hB));

  assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stall && statusOut == CODE_HOLD) |=> (stall && (statusOut == CODE_HOLD || statusOut == CODE_TAKEN)));

  assert_disabled_plain_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && capValid && cfgBytes == 2'd0) |=> (!stall && statusOut == CODE_TAKEN));

endmodule

// File: rtl/trace_encoder.sv
module trace_encoder
  import trace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        instStatus,
  input  logic              capValid,
  input  logic [ADDR_W-1:0] capTarget,
  input  logic [1:0]        cfgBytes,
  output logic [3:0]        traceStatus,
  output logic [3:0]        traceData,
  output logic              pipeStall
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] freeSlots;
  logic [1:0]       heldCfg;

  trace_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instStatus (instStatus),
    .capValid   (capValid),
    .cfgBytes   (cfgBytes),
    .freeSlots  (freeSlots),
    .heldCfg    (heldCfg),
    .strobe     (strobe),
    .statusOut  (traceStatus),
    .stall      (pipeStall)
  );

  trace_datapath #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .liveTarget (capTarget),
    .liveCfg    (cfgBytes),
    .freeSlots  (freeSlots),
    .heldCfg    (heldCfg),
    .dataOut    (traceData)
  );

endmodule

// File: tb/trace_encoder_bench.sv
`timescale 1ns/1ps
module trace_encoder_bench;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  instStatus;
  logic        capValid;
  logic [31:0] capTarget;
  logic [1:0]  cfgBytes;
  logic [3:0]  traceStatus;
  logic [3:0]  traceData;
  logic        pipeStall;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          mState = 0;  // 0 idle, 1 marker slot, 2 waiting for room
  logic [31:0] mHeldT;
  logic [1:0]  mHeldC;
  logic [3:0]  q[$];
  logic [3:0]  expStatus = 4'h0;
  logic [3:0]  expData   = 4'h0;
  logic        expStall  = 1'b0;

  always #2.5 clk = ~clk;

  trace_encoder u_trace_encoder (
    .clk(clk), .rstN(rstN), .instStatus(instStatus), .capValid(capValid),
    .capTarget(capTarget), .cfgBytes(cfgBytes), .traceStatus(traceStatus),
    .traceData(traceData), .pipeStall(pipeStall)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushNibs(input logic [31:0] t, input logic [1:0] c);
    for (int i = 0; i < 2 * (c + 1); i++) q.push_back(t[4*i +: 4]);
  endtask

  // advance the model by one rising edge with the given inputs
  task automatic modelStep(input logic cv, input logic [31:0] tg, input logic [3:0] st, input logic [1:0] cf);
    int freeNow;
    freeNow = DEPTH - q.size();
    expData = (q.size() != 0) ? q.pop_front() : 4'h0;
    case (mState)
      0: begin
        if (cv && cf != 0) begin
          mHeldT = tg; mHeldC = cf;
          if (freeNow >= 2 * (cf + 1)) begin
            pushNibs(tg, cf); expStatus = 4'h5; mState = 1;
          end else begin
            expStatus = 4'h0; mState = 2;
          end
        end else if (cv) expStatus = 4'h5;
        else expStatus = st;
      end
      1: begin
        expStatus = 4'h8 + 4'(mHeldC); mState = 0;
      end
      default: begin
        if (freeNow >= 2 * (mHeldC + 1)) begin
          pushNibs(mHeldT, mHeldC); expStatus = 4'h5; mState = 1;
        end else expStatus = 4'h0;
      end
    endcase
    expStall = (mState != 0);
  endtask

  task automatic compareAll();
    chk(traceStatus === expStatus, "R2/R3/R6/R9 status", 32'(traceStatus), 32'(expStatus));
    chk(traceData === expData, "R4/R5/R8/R9 data", 32'(traceData), 32'(expData));
    chk(pipeStall === expStall, "R3/R6/R7 stall", 32'(pipeStall), 32'(expStall));
  endtask

  task automatic doCycle(input logic cv, input logic [31:0] tg, input logic [3:0] st, input logic [1:0] cf);
    capValid = cv; capTarget = tg; instStatus = st; cfgBytes = cf;
    modelStep(cv, tg, st, cf);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  // while the model says stalled, drive conflicting inputs (R7), then the real request
  task automatic issue(input logic cv, input logic [31:0] tg, input logic [3:0] st, input logic [1:0] cf);
    while (expStall) doCycle(1'b1, ~tg, 4'hE, ~cf);
    doCycle(cv, tg, st, cf);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 32'h0, 4'(i + 1), 2'd1);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; capValid = 1'b0; capTarget = '0; instStatus = 4'h0; cfgBytes = 2'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(traceStatus === 4'h0 && traceData === 4'h0 && pipeStall === 1'b0, "R1 reset outputs",
          {traceStatus, traceData, 3'b0, pipeStall}, 32'h0);
    end
    rstN = 1'b1;

    // R2 plain status pass-through
    issue(1'b0, 32'h0, 4'h1, 2'd1);
    issue(1'b0, 32'h0, 4'h3, 2'd1);
    issue(1'b0, 32'h0, 4'hC, 2'd1);
    // R3/R4/R5/R8: 2, 3, 4 byte captures with traffic behind them
    issue(1'b1, 32'h1234_ABCD, 4'h1, 2'd1);
    idle(10);
    issue(1'b1, 32'h89AB_CDEF, 4'h1, 2'd2);
    idle(10);
    issue(1'b1, 32'hFEDC_BA98, 4'h1, 2'd3);
    idle(12);
    // R6/R7: a 2-byte capture immediately followed by a 4-byte one that must wait
    issue(1'b1, 32'h0000_5A5A, 4'h1, 2'd1);
    issue(1'b1, 32'h7654_3210, 4'h1, 2'd3);
    idle(14);
    // R6: two 3-byte captures back to back
    issue(1'b1, 32'h00C0_FFEE, 4'h2, 2'd2);
    issue(1'b1, 32'h0012_3456, 4'h2, 2'd2);
    idle(14);
    // R9: feature off
    issue(1'b1, 32'hDEAD_BEEF, 4'h1, 2'd0);
    issue(1'b1, 32'hCAFE_F00D, 4'h1, 2'd0);
    idle(4);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      issue(r[2:0] == 3'd0, $urandom(), r[7:4], r[9:8]);
    end
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule